// File: doc/BRIEF.md
# I2C Target Receiver with Masked Addressing

This block is the receive half of an I2C target. It watches SCL and SDA with the system clock and finds START and STOP conditions. After each START it shifts in the address byte and decides whether to accept it. A transaction is accepted on any of three terms:

- the primary address matches exactly;
- the alternate address matches on every bit that its mask does not cover;
- promiscuous mode is on, which accepts any address.

An accepted write transaction is ACKed byte by byte. Every received byte goes into a small receive FIFO. Each FIFO entry carries flags that describe the bus context of that byte.

A host drains the FIFO through a show-ahead pop interface. Each entry is 13 bits wide:

- data in bits 7:0;
- EMPTY in bit 8;
- OVERFLOW in bit 9;
- START-before in bit 10;
- STOP in bit 11;
- NACK-after in bit 12.

An entry with the STOP bit set marks the end of a write transaction and carries no valid data. A NACK-next input makes the target refuse the byte being received. Busy flags report whether a read or a write transaction is running. SCL and SDA are expected to be already synchronized to `clk`. The target pulls SDA low only while it is driving an ACK.

Top module: `i2c_target_rx`

## Requirements
- R1: With `en_prim` set, an address byte whose bits 7:1 equal `prim_addr` is ACKed: `sda_pull_o` is high during the ninth SCL pulse, and only in state START-ACK or ACK.
- R2: With `en_alt` set, an address matches when every address bit whose `alt_mask` bit is 0 equals the corresponding bit of `alt_addr`. A mask bit of 1 makes that address bit don't-care.
- R3: With `promisc` set, every address is ACKed and its write data is stored.
- R4: An address that matches no enabled term gets no ACK, returns the target to IDLE (0), and writes nothing into the FIFO.
- R5: Each byte of an accepted write is stored with its data in bits 7:0 and EMPTY clear. The first entry written after a START has bit 10 set; later entries have it clear.
- R6: A STOP that ends an accepted write pushes an entry with bit 11 set and data 0. Any STOP returns the state to IDLE on the next cycle.
- R7: While `nack_next` is high at the end of a data byte, that byte is not ACKed. It is still stored, with bit 12 set.
- R8: In promiscuous mode, a byte or STOP entry that meets a full FIFO is dropped. The next entry written carries bit 9 set.
- R9: Outside promiscuous mode, a data byte that meets a full FIFO is NACKed and dropped without setting any flag.
- R10: When the FIFO is empty, `fifo_entry` reads 0x100, with only EMPTY set.
- R11: `state_o` encodes IDLE=0, START=1, START-ACK=2, DATA=3 and ACK=4. `wr_busy` is high from the ACK of a write address until STOP or a new START.
- R12: An accepted address with the read bit (bit 0) set is ACKed, raises `rd_busy` until STOP, leaves the state in IDLE, and stores nothing.
- R13: `fifo_full` is high when the FIFO holds `FIFO_DEPTH` entries. `fifo_not_empty` is high when it holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK) |
| en_prim | input | 1 | Enable primary address match |
| prim_addr | input | 7 | Primary 7-bit address |
| en_alt | input | 1 | Enable masked alternate match |
| alt_addr | input | 7 | Alternate 7-bit address |
| alt_mask | input | 7 | 1 = address bit ignored |
| promisc | input | 1 | Accept every address |
| nack_next | input | 1 | Refuse the byte now being received |
| fifo_pop | input | 1 | Remove the head entry |
| fifo_entry | output | 13 | Head entry, or 0x100 when empty |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH entries |
| fifo_not_empty | output | 1 | FIFO holds at least one entry |
| wr_busy | output | 1 | Write transaction in progress |
| rd_busy | output | 1 | Read transaction in progress |
| state_o | output | 3 | Target state code |

## Verification
Two functions can fall in the same cycle: pushing a received byte into the FIFO, and deciding whether that byte's ACK is possible. When the FIFO is already full, the same edge that ends the byte must both drop it and choose between a NACK and a pending overflow mark.

The bench provokes this by pausing the draining monitor and sending a fifth byte into a four-entry FIFO, once in promiscuous mode and once outside it. It judges the result by the ACK level sampled on the bus. It then resumes draining and checks whether the first entry of the next transaction carries the overflow bit.

// File: rtl/i2c_rx_pkg.sv
// Shared constants and types for the I2C target receive path.
// Assumes 7-bit addressing with the R/W flag in bit 0 of the address byte.
package i2c_rx_pkg;

    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;
    localparam int ENTRY_W = 13;

    // Target controller state; codes are visible on state_o
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_SACK  = 3'd2,
        ST_DATA  = 3'd3,
        ST_ACK   = 3'd4
    } tgt_state_e;

    // One receive-FIFO entry, MSB first: bit 12 down to bit 0
    typedef struct packed {
        logic              nack;
        logic              stop;
        logic              start;
        logic              ovf;
        logic              empty;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/i2c_rx_addr_match.sv
// Address comparator: primary exact match, masked alternate match, or
// promiscuous acceptance. Purely combinational.
// Assumes the caller presents the 7-bit address without the R/W bit.
module i2c_rx_addr_match #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] addr,
    input  logic          en_prim,
    input  logic [AW-1:0] prim_addr,
    input  logic          en_alt,
    input  logic [AW-1:0] alt_addr,
    input  logic [AW-1:0] alt_mask,
    input  logic          promisc,
    output logic          hit
);

    logic [AW-1:0] alt_bit_ok;

    // A masked bit always agrees; otherwise the bit must be equal
    for (genvar i = 0; i < AW; i++) begin : g_alt_bit
        assign alt_bit_ok[i] = alt_mask[i] | (addr[i] ~^ alt_addr[i]);
    end

    // Combine the three acceptance terms
    always_comb begin
        hit = promisc
            | (en_prim & (addr == prim_addr))
            | (en_alt & (&alt_bit_ok));
    end

endmodule

// File: rtl/i2c_rx_fifo.sv
// Synchronous show-ahead FIFO for receive entries.
// A push while full and a pop while empty are ignored.
// Assumes DEPTH >= 2.
module i2c_rx_fifo #(
    parameter int W     = 13,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         not_empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    // Pointer advance with wrap for any depth
    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push & ~full;
    assign do_pop    = pop & not_empty;
    assign dout      = mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/i2c_rx_bus.sv
// Bit engine and state machine of the target receiver.
// It oversamples SCL/SDA with clk, detects START/STOP, shifts in the
// address and data bytes, drives ACKs, and forms tagged FIFO entries.
// Assumes scl_i/sda_i are already synchronized and that each SCL level
// lasts at least two clk cycles.
module i2c_rx_bus
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_hit,
    input  logic              promisc,
    input  logic              nack_next,
    input  logic              fifo_full,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sda_pull,
    output logic              push,
    output rx_entry_t         push_entry,
    output tgt_state_e        state,
    output logic              wr_busy,
    output logic              rd_busy
);

    logic              scl_q, sda_q;
    logic              scl_rise, scl_fall, start_cond, stop_cond;
    tgt_state_e        state_n;
    logic [BYTE_W-1:0] sh, sh_n;
    logic [3:0]        cnt, cnt_n;
    logic              ack_q, ack_n;
    logic              wr_n, rd_n;
    logic              start_pend, start_pend_n;
    logic              ovf_pend, ovf_pend_n;

    assign scl_rise   = scl_i & ~scl_q;
    assign scl_fall   = ~scl_i & scl_q;
    assign start_cond = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_cond  = scl_i & scl_q & ~sda_q & sda_i;
    assign addr_o     = sh[BYTE_W-1:1];
    assign sda_pull   = ack_q;

    // Next-state, shift, ACK and FIFO-entry decisions
    always_comb begin
        state_n      = state;
        sh_n         = sh;
        cnt_n        = cnt;
        ack_n        = ack_q;
        wr_n         = wr_busy;
        rd_n         = rd_busy;
        start_pend_n = start_pend;
        ovf_pend_n   = ovf_pend;
        push         = 1'b0;
        push_entry   = '0;
        if (stop_cond) begin
            state_n = ST_IDLE;
            ack_n   = 1'b0;
            wr_n    = 1'b0;
            rd_n    = 1'b0;
            if (wr_busy) begin
                if (!fifo_full) begin
                    push             = 1'b1;
                    push_entry.stop  = 1'b1;
                    push_entry.start = start_pend;
                    push_entry.ovf   = ovf_pend;
                    start_pend_n     = 1'b0;
                    ovf_pend_n       = 1'b0;
                end else if (promisc) begin
                    ovf_pend_n = 1'b1;
                end
            end
        end else if (start_cond) begin
            state_n      = ST_START;
            cnt_n        = '0;
            ack_n        = 1'b0;
            wr_n         = 1'b0;
            rd_n         = 1'b0;
            start_pend_n = 1'b1;
        end else begin
            case (state)
                ST_START, ST_DATA: begin
                    if (scl_rise && cnt < 4'd8) begin
                        sh_n  = {sh[BYTE_W-2:0], sda_i};
                        cnt_n = cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt_n = '0;
                        if (state == ST_START) begin
                            state_n = addr_hit ? ST_SACK : ST_IDLE;
                            ack_n   = addr_hit;
                        end else begin
                            state_n = ST_ACK;
                            if (!fifo_full) begin
                                push             = 1'b1;
                                push_entry.data  = sh;
                                push_entry.nack  = nack_next;
                                push_entry.start = start_pend;
                                push_entry.ovf   = ovf_pend;
                                start_pend_n     = 1'b0;
                                ovf_pend_n       = 1'b0;
                                ack_n            = ~nack_next;
                            end else if (promisc) begin
                                ovf_pend_n = 1'b1;
                                ack_n      = ~nack_next;
                            end else begin
                                ack_n = 1'b0;
                            end
                        end
                    end
                end
                ST_SACK: begin
                    if (scl_fall) begin
                        ack_n = 1'b0;
                        cnt_n = '0;
                        if (sh[0]) begin
                            state_n = ST_IDLE;
                            rd_n    = 1'b1;
                        end else begin
                            state_n = ST_DATA;
                            wr_n    = 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ack_n   = 1'b0;
                        state_n = ST_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    // Line history; loaded from the pins even in reset so edges are clean
    always_ff @(posedge clk) begin
        scl_q <= scl_i;
        sda_q <= sda_i;
    end

    // State and context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sh         <= '0;
            cnt        <= '0;
            ack_q      <= 1'b0;
            wr_busy    <= 1'b0;
            rd_busy    <= 1'b0;
            start_pend <= 1'b0;
            ovf_pend   <= 1'b0;
        end else begin
            state      <= state_n;
            sh         <= sh_n;
            cnt        <= cnt_n;
            ack_q      <= ack_n;
            wr_busy    <= wr_n;
            rd_busy    <= rd_n;
            start_pend <= start_pend_n;
            ovf_pend   <= ovf_pend_n;
        end
    end

endmodule

// File: rtl/i2c_target_rx.sv
// Top of the I2C target receiver: bit engine, address comparator and
// tagged receive FIFO. The head entry reads as EMPTY-only when nothing
// is stored. Assumes synchronized bus inputs and an open-drain SDA
// driven through sda_pull_o.
module i2c_target_rx
    import i2c_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic               en_prim,
    input  logic [ADDR_W-1:0]  prim_addr,
    input  logic               en_alt,
    input  logic [ADDR_W-1:0]  alt_addr,
    input  logic [ADDR_W-1:0]  alt_mask,
    input  logic               promisc,
    input  logic               nack_next,
    input  logic               fifo_pop,
    output logic [ENTRY_W-1:0] fifo_entry,
    output logic               fifo_full,
    output logic               fifo_not_empty,
    output logic               wr_busy,
    output logic               rd_busy,
    output logic [2:0]         state_o
);

    logic [ADDR_W-1:0]  addr_w;
    logic               hit_w;
    logic               push_w;
    rx_entry_t          push_entry_w;
    tgt_state_e         state_w;
    logic [ENTRY_W-1:0] head_w;
    rx_entry_t          empty_entry;

    i2c_rx_addr_match #(.AW(ADDR_W)) u_match (
        .addr      (addr_w),
        .en_prim   (en_prim),
        .prim_addr (prim_addr),
        .en_alt    (en_alt),
        .alt_addr  (alt_addr),
        .alt_mask  (alt_mask),
        .promisc   (promisc),
        .hit       (hit_w)
    );

    i2c_rx_bus u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .addr_hit   (hit_w),
        .promisc    (promisc),
        .nack_next  (nack_next),
        .fifo_full  (fifo_full),
        .addr_o     (addr_w),
        .sda_pull   (sda_pull_o),
        .push       (push_w),
        .push_entry (push_entry_w),
        .state      (state_w),
        .wr_busy    (wr_busy),
        .rd_busy    (rd_busy)
    );

    i2c_rx_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_w),
        .din       (push_entry_w),
        .pop       (fifo_pop),
        .dout      (head_w),
        .full      (fifo_full),
        .not_empty (fifo_not_empty)
    );

    // Present the EMPTY-only pattern when no entry is stored
    always_comb begin
        empty_entry       = '0;
        empty_entry.empty = 1'b1;
        fifo_entry        = fifo_not_empty ? head_w : empty_entry;
        state_o           = state_w;
    end

endmodule

// File: rtl/i2c_target_rx_chk.sv
// Assertion checker for i2c_target_rx, attached with bind below.
// Observes ports plus the push strobe between bit engine and FIFO.
module i2c_target_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_i,
    input logic        sda_pull_o,
    input logic [2:0]  state_o,
    input logic        wr_busy,
    input logic        rd_busy,
    input logic        fifo_full,
    input logic        fifo_not_empty,
    input logic [12:0] fifo_entry,
    input logic        push
);

    AST_PULL_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> (state_o == 3'd2 || state_o == 3'd4));  // R1

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);  // R11

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_busy && rd_busy));  // R11

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> state_o == 3'd0);  // R6

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> fifo_not_empty);  // R13

    AST_EMPTY_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_not_empty |-> fifo_entry == 13'h100);  // R10

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && fifo_full));  // R9

endmodule

bind i2c_target_rx i2c_target_rx_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl_i),
    .sda_i          (sda_i),
    .sda_pull_o     (sda_pull_o),
    .state_o        (state_o),
    .wr_busy        (wr_busy),
    .rd_busy        (rd_busy),
    .fifo_full      (fifo_full),
    .fifo_not_empty (fifo_not_empty),
    .fifo_entry     (fifo_entry),
    .push           (push_w)
);

// File: tb/i2c_target_rx_test.sv
// Scoreboard bench: bus tasks queue expected FIFO entries, a monitor
// drains the FIFO and compares each entry.
module i2c_target_rx_test;

    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    wire         sda_pull;
    wire         sda_line = sda_drv & ~sda_pull;
    logic        en_prim = 1'b0, en_alt = 1'b0, promisc = 1'b0, nack_next = 1'b0;
    logic [6:0]  prim_addr = 7'h00, alt_addr = 7'h00, alt_mask = 7'h00;
    logic        fifo_pop = 1'b0;
    wire  [12:0] fifo_entry;
    wire         fifo_full, fifo_not_empty, wr_busy, rd_busy;
    wire  [2:0]  state;

    int          total = 0;
    int          bad = 0;
    bit          mon_on = 1'b0;
    logic [12:0] expq[$];

    always #2 clk = ~clk;

    i2c_target_rx uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .en_prim(en_prim), .prim_addr(prim_addr),
        .en_alt(en_alt), .alt_addr(alt_addr), .alt_mask(alt_mask),
        .promisc(promisc), .nack_next(nack_next), .fifo_pop(fifo_pop),
        .fifo_entry(fifo_entry), .fifo_full(fifo_full),
        .fifo_not_empty(fifo_not_empty), .wr_busy(wr_busy),
        .rd_busy(rd_busy), .state_o(state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic q_wait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl) begin
            sda_drv = 1'b1; q_wait();
            scl = 1'b1;     q_wait();
        end
        sda_drv = 1'b0; q_wait();
        scl = 1'b0;     q_wait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; q_wait();
        scl = 1'b1;     q_wait();
        sda_drv = 1'b1; q_wait();
        q_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit got;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; q_wait();
            scl = 1'b1;     q_wait(); q_wait();
            scl = 1'b0;     q_wait();
        end
        sda_drv = 1'b1; q_wait();
        scl = 1'b1;     q_wait();
        got = (sda_line == 1'b0);
        q_wait();
        scl = 1'b0;     q_wait();
        chk(got == exp_ack, req, got, exp_ack);
    endtask

    task automatic expect_entry(input logic [12:0] e);
        expq.push_back(e);
    endtask

    task automatic drain(input string req);
        repeat (40) @(negedge clk);
        chk(expq.size() == 0, req, expq.size(), 0);
    endtask

    // Monitor: pops each stored entry and compares it to the scoreboard
    always @(negedge clk) begin
        if (mon_on && fifo_not_empty && !fifo_pop) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected entry", fifo_entry, 0);
            end else begin
                logic [12:0] e;
                e = expq.pop_front();
                chk(fifo_entry == e, "R5/R6/R7/R8/R9 entry", fifo_entry, e);
            end
            fifo_pop = 1'b1;
        end else begin
            fifo_pop = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 / R11 reset state
        chk(state == 3'd0, "R11 reset state", state, 0);
        chk(fifo_entry == 13'h100, "R10 empty entry", fifo_entry, 13'h100);
        chk(fifo_not_empty == 1'b0, "R13 reset not_empty", fifo_not_empty, 0);
        mon_on = 1'b1;

        // R1 R5 R6 primary write
        en_prim = 1'b1; prim_addr = 7'h3A;
        expect_entry(13'h411); expect_entry(13'h022); expect_entry(13'h800);
        bus_start();
        send_byte({7'h3A, 1'b0}, 1'b1, "R1 primary ack");
        chk(state == 3'd3, "R11 data state", state, 3);
        chk(wr_busy == 1'b1, "R11 wr_busy", wr_busy, 1);
        send_byte(8'h11, 1'b1, "R5 data ack");
        send_byte(8'h22, 1'b1, "R5 data ack");
        bus_stop();
        chk(state == 3'd0 && wr_busy == 1'b0, "R6 idle after stop", state, 0);
        drain("R6 drained");

        // R4 mismatch
        bus_start();
        send_byte({7'h3B, 1'b0}, 1'b0, "R4 no ack");
        chk(state == 3'd0, "R4 idle", state, 0);
        send_byte(8'h55, 1'b0, "R4 data ignored");
        bus_stop();
        drain("R4 nothing stored");

        // R2 masked alternate
        en_prim = 1'b0; en_alt = 1'b1; alt_addr = 7'h50; alt_mask = 7'h0F;
        expect_entry(13'h4C3); expect_entry(13'h800);
        bus_start();
        send_byte({7'h5C, 1'b0}, 1'b1, "R2 masked match");
        send_byte(8'hC3, 1'b1, "R2 data");
        bus_stop();
        bus_start();
        send_byte({7'h6C, 1'b0}, 1'b0, "R2 masked miss");
        bus_stop();
        drain("R2 drained");

        // R3 promiscuous
        en_alt = 1'b0; promisc = 1'b1;
        expect_entry(13'h45A); expect_entry(13'h800);
        bus_start();
        send_byte({7'h01, 1'b0}, 1'b1, "R3 any address");
        send_byte(8'h5A, 1'b1, "R3 data");
        bus_stop();
        drain("R3 drained");

        // R7 nack_next
        promisc = 1'b0; en_prim = 1'b1;
        expect_entry(13'h1477); expect_entry(13'h800);
        bus_start();
        send_byte({7'h3A, 1'b0}, 1'b1, "R7 addr");
        nack_next = 1'b1;
        send_byte(8'h77, 1'b0, "R7 refused");
        nack_next = 1'b0;
        bus_stop();
        drain("R7 drained");

        // R12 read request
        bus_start();
        send_byte({7'h3A, 1'b1}, 1'b1, "R12 read ack");
        chk(rd_busy == 1'b1 && state == 3'd0, "R12 rd_busy", {rd_busy, state}, 4'h8);
        bus_stop();
        chk(rd_busy == 1'b0, "R12 rd_busy clear", rd_busy, 0);
        drain("R12 nothing stored");

        // R8 overflow in promiscuous mode
        mon_on = 1'b0; promisc = 1'b1;
        bus_start();
        send_byte({7'h3A, 1'b0}, 1'b1, "R8 addr");
        send_byte(8'h11, 1'b1, "R8 b1");
        send_byte(8'h22, 1'b1, "R8 b2");
        send_byte(8'h33, 1'b1, "R8 b3");
        send_byte(8'h44, 1'b1, "R8 b4");
        send_byte(8'h55, 1'b1, "R8 ack when full");
        bus_stop();
        chk(fifo_full == 1'b1, "R13 full", fifo_full, 1);
        chk(fifo_entry == 13'h411, "R8 head", fifo_entry, 13'h411);
        expect_entry(13'h411); expect_entry(13'h022);
        expect_entry(13'h033); expect_entry(13'h044);
        mon_on = 1'b1;
        drain("R8 drained");
        expect_entry(13'h699); expect_entry(13'h800);
        bus_start();
        send_byte({7'h3A, 1'b0}, 1'b1, "R8 addr2");
        send_byte(8'h99, 1'b1, "R8 flagged byte");
        bus_stop();
        drain("R8 overflow flag");

        // R9 full outside promiscuous mode
        mon_on = 1'b0; promisc = 1'b0;
        bus_start();
        send_byte({7'h3A, 1'b0}, 1'b1, "R9 addr");
        send_byte(8'hA1, 1'b1, "R9 b1");
        send_byte(8'hA2, 1'b1, "R9 b2");
        send_byte(8'hA3, 1'b1, "R9 b3");
        send_byte(8'hA4, 1'b1, "R9 b4");
        send_byte(8'hA5, 1'b0, "R9 nack when full");
        bus_stop();
        expect_entry(13'h4A1); expect_entry(13'h0A2);
        expect_entry(13'h0A3); expect_entry(13'h0A4);
        mon_on = 1'b1;
        drain("R9 drained");
        expect_entry(13'h442); expect_entry(13'h800);
        bus_start();
        send_byte({7'h3A, 1'b0}, 1'b1, "R9 addr2");
        send_byte(8'h42, 1'b1, "R9 no flag");
        bus_stop();
        drain("R9 no overflow flag");
        chk(fifo_entry == 13'h100, "R10 empty at end", fifo_entry, 13'h100);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule